// File: doc/BRIEF.md
# Break-Aware Serial Transmit/Receive Flag Controller

This block owns the transmit-empty and receive-full flags of a serial port, together with a one-entry transmit holding buffer and a receive data latch. It decides when a software access on its small register bus may change those flags. When a debug halt is active, a software-controlled enable bit chooses between two behaviours. In the first, software accesses are free of side effects. In the second, clears behave exactly as they do in normal running.

The shifter itself is not part of this block. The block hands it one byte at a time through a single-cycle load strobe, and it learns of finished transfers through two event inputs: one for shift completion and one for receive completion. Hardware events always take effect, including during a halt. Only software-initiated clears are gated.

The receive flag uses a two-step clear. A status read while the flag is set arms the clear, and a later data read completes it. An armed clear survives a protected halt and can be completed after the halt ends.

Top module: `spi_brk_flags`

## Requirements
- R1: After a synchronous active-high reset, the status word reads bit0 (halt-clear enable) = 0, bit1 (transmit-empty) = 1, bit2 (receive-full) = 0, and the load strobe is low.
- R2: A write to address 0 loads bit0 of the write data into the halt-clear enable. Reading address 0 returns {rx_full, tx_empty, enable} in bits 2..0, with the upper bits at zero.
- R3: A data write (address 1) that is accepted while transmit-empty is 1 and the shifter is idle drives transmit-empty to 0 and asserts ld_strobe with that data for exactly the one cycle after the write edge. Transmit-empty returns to 1 at the next edge.
- R4: A data write while transmit-empty is 0 is ignored, and the pending byte is kept unchanged.
- R5: While the shifter is busy, an accepted byte waits. ld_strobe rises in the same cycle that shift_done is high, and transmit-empty is set at that edge.
- R6: rx_done sets receive-full and captures rx_data, which a read of address 1 returns. This also works during a halt.
- R7: Receive-full clears only on a data read that follows a status read made while receive-full was 1. A data read with no prior arming status read leaves the flag unchanged.
- R8: With halt active and enable = 0, a data write has no effect: no load strobe, transmit-empty stays 1, and nothing is pending after the halt ends.
- R9: With halt active and enable = 0, data reads do not clear receive-full. A clear armed before the halt is kept, and a data read after the halt completes it.
- R10: With enable = 1, clears and data writes during a halt act as in normal running, and a flag cleared during the halt stays cleared after it.
- R11: An rx_done in the same cycle as an armed clearing data read leaves receive-full at 1 and discards the arming, so a further data read does not clear the flag.
- R12: A status read during a protected halt does not arm the receive clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects) |
| bus_addr | input | 1 | 0 = status/control, 1 = data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational from current state) |
| dbg_halt | input | 1 | Debug halt state active |
| shift_done | input | 1 | Shifter finished its current byte |
| rx_done | input | 1 | A received byte is valid on rx_data |
| rx_data | input | DW | Received byte |
| ld_strobe | output | 1 | Load request to the shifter |
| ld_data | output | DW | Byte to load into the shifter |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a receive completion and the data read that finishes an armed clear. The bench provokes this by raising rx_done in the same cycle as that read. It passes when receive-full is still set afterwards and a second data read does not clear it. The second pair is shift completion and the handoff of a waiting byte. The bench holds shift_done for one cycle while a byte is pending. It passes when ld_strobe rises with the pending byte in that same cycle and transmit-empty is set at that edge, while a byte rejected earlier never shows up on ld_data.

// File: rtl/spi_brk_pkg.sv
package spi_brk_pkg;

    typedef enum logic {
        SEL_STAT = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    localparam int BIT_EN  = 0;
    localparam int BIT_TXE = 1;
    localparam int BIT_RXF = 2;
    localparam int STAT_BITS = 3;

    typedef struct packed {
        logic ctl_wr;
        logic dat_wr;
        logic stat_rd;
        logic dat_rd;
    } bus_ops_t;

    // Software-side clears are allowed outside a halt, or inside it when enabled.
    function automatic logic sw_clear_ok(input logic halt, input logic en);
        return !halt || en;
    endfunction

endpackage

// File: rtl/spi_brk_decode.sv
module spi_brk_decode
    import spi_brk_pkg::*;
(
    input  logic     bus_wr,
    input  logic     bus_rd,
    input  logic     bus_addr,
    output bus_ops_t ops
);
    always_comb begin
        ops.ctl_wr  = bus_wr && (bus_addr == SEL_STAT);
        ops.dat_wr  = bus_wr && (bus_addr == SEL_DATA);
        ops.stat_rd = bus_rd && (bus_addr == SEL_STAT);
        ops.dat_rd  = bus_rd && (bus_addr == SEL_DATA);
    end
endmodule

// File: rtl/spi_brk_tx.sv
module spi_brk_tx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [DW-1:0] wdata,
    input  logic          sw_ok,
    input  logic          shift_done,
    output logic          tx_empty,
    output logic          ld_strobe,
    output logic [DW-1:0] ld_data
);
    logic          pend_q;
    logic          busy_q;
    logic [DW-1:0] hold_q;
    logic          accept;

    assign accept    = wr_req && sw_ok && !pend_q;
    assign ld_strobe = pend_q && (!busy_q || shift_done);
    assign ld_data   = hold_q;
    assign tx_empty  = !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (accept) begin
                pend_q <= 1'b1;
                hold_q <= wdata;
            end else if (ld_strobe) begin
                pend_q <= 1'b0;
            end
            if (ld_strobe)
                busy_q <= 1'b1;
            else if (shift_done)
                busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_brk_rx.sv
module spi_brk_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_data,
    input  logic          stat_rd,
    input  logic          dat_rd,
    input  logic          sw_ok,
    output logic          rx_full,
    output logic [DW-1:0] rx_buf
);
    logic arm_q;
    logic finish;

    assign finish = dat_rd && sw_ok && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full <= 1'b0;
            arm_q   <= 1'b0;
            rx_buf  <= '0;
        end else begin
            if (rx_done) begin
                rx_full <= 1'b1;
                rx_buf  <= rx_data;
                arm_q   <= 1'b0;
            end else if (finish) begin
                rx_full <= 1'b0;
                arm_q   <= 1'b0;
            end else if (stat_rd && sw_ok && rx_full) begin
                arm_q   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_brk_flags.sv
module spi_brk_flags
    import spi_brk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dbg_halt,
    input  logic          shift_done,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_data,
    output logic          ld_strobe,
    output logic [DW-1:0] ld_data
);
    localparam int PAD_W = DW - STAT_BITS;

    bus_ops_t      ops;
    logic          bce_q;
    logic          sw_ok;
    logic          tx_empty;
    logic          rx_full;
    logic [DW-1:0] rx_buf;
    logic [STAT_BITS-1:0] stat_bits;

    spi_brk_decode u_dec (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .ops     (ops)
    );

    assign sw_ok = sw_clear_ok(dbg_halt, bce_q);

    always_ff @(posedge clk) begin
        if (rst)
            bce_q <= 1'b0;
        else if (ops.ctl_wr)
            bce_q <= bus_wdata[BIT_EN];
    end

    spi_brk_tx #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (ops.dat_wr),
        .wdata     (bus_wdata),
        .sw_ok     (sw_ok),
        .shift_done(shift_done),
        .tx_empty  (tx_empty),
        .ld_strobe (ld_strobe),
        .ld_data   (ld_data)
    );

    spi_brk_rx #(.DW(DW)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .rx_done(rx_done),
        .rx_data(rx_data),
        .stat_rd(ops.stat_rd),
        .dat_rd (ops.dat_rd),
        .sw_ok  (sw_ok),
        .rx_full(rx_full),
        .rx_buf (rx_buf)
    );

    always_comb begin
        stat_bits          = '0;
        stat_bits[BIT_EN]  = bce_q;
        stat_bits[BIT_TXE] = tx_empty;
        stat_bits[BIT_RXF] = rx_full;
    end

    assign bus_rdata = (bus_addr == SEL_DATA) ? rx_buf
                                               : {{PAD_W{1'b0}}, stat_bits};
endmodule

// File: rtl/spi_brk_flags_chk.sv
module spi_brk_flags_chk (
    input logic clk,
    input logic rst,
    input logic dbg_halt,
    input logic bce,
    input logic tx_empty,
    input logic rx_full,
    input logic ld_strobe,
    input logic rx_done
);
    logic guarded;
    assign guarded = dbg_halt && !bce;

    assert_ld_single_R3: assert property (@(posedge clk) disable iff (rst)
        ld_strobe |=> (!ld_strobe && tx_empty));

    assert_pending_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (!tx_empty && !ld_strobe) |=> !tx_empty);

    assert_rx_set_R6: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rx_full);

    assert_txe_guarded_R8: assert property (@(posedge clk) disable iff (rst)
        (guarded && tx_empty) |=> tx_empty);

    assert_rxf_guarded_R9: assert property (@(posedge clk) disable iff (rst)
        (guarded && rx_full) |=> rx_full);
endmodule

bind spi_brk_flags spi_brk_flags_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dbg_halt (dbg_halt),
    .bce      (bce_q),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .ld_strobe(ld_strobe),
    .rx_done  (rx_done)
);

// File: tb/spi_brk_flags_bench.sv
module spi_brk_flags_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr, bus_rd, bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          dbg_halt, shift_done, rx_done;
    logic [DW-1:0] rx_data;
    logic          ld_strobe;
    logic [DW-1:0] ld_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    spi_brk_flags #(.DW(DW)) u_spi_brk_flags (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .shift_done(shift_done), .rx_done(rx_done),
        .rx_data(rx_data), .ld_strobe(ld_strobe), .ld_data(ld_data)
    );

    // [4]=rx_done [3:2]=op (0 none, 1 status read, 2 data read) [1]=halt [0]=expected rx_full
    localparam logic [4:0] VEC [0:15] = '{
        5'b1_00_0_1, 5'b0_01_0_1, 5'b0_10_0_0, 5'b1_00_0_1,
        5'b0_10_0_1, 5'b0_01_0_1, 5'b0_10_1_1, 5'b0_01_1_1,
        5'b0_10_1_1, 5'b0_10_0_0, 5'b1_00_1_1, 5'b0_01_1_1,
        5'b0_10_0_1, 5'b0_01_0_1, 5'b1_10_0_1, 5'b0_10_0_1
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = '0;
        shift_done = 0; rx_done = 0;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic stat_peek(output logic [DW-1:0] s);
        bus_addr = 0; bus_rd = 0; bus_wr = 0;
        #1 s = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        tick();
        idle();
    endtask

    logic [DW-1:0] s;

    initial begin
        rst = 1; dbg_halt = 0; rx_data = '0; idle();
        tick(); tick();
        rst = 0;
        #1;
        stat_peek(s);
        chk("R1 status", s, 8'h02);
        chk("R1 ld_strobe", {7'b0, ld_strobe}, 8'h00);

        // table walk: receive flag sequencing, enable = 0
        for (int i = 0; i < 16; i++) begin
            rx_done  = VEC[i][4];
            rx_data  = 8'(i * 17 + 3);
            dbg_halt = VEC[i][1];
            bus_rd   = (VEC[i][3:2] != 2'd0);
            bus_addr = (VEC[i][3:2] == 2'd2);
            tick();
            idle();
            stat_peek(s);
            chk($sformatf("R7/R9/R11/R12 vec%0d rx_full", i), {7'b0, s[2]}, {7'b0, VEC[i][0]});
        end
        dbg_halt = 0;

        // R6: captured data readable
        rx_done = 1; rx_data = 8'h5A; tick(); idle();
        bus_addr = 1; #1 chk("R6 rx data", bus_rdata, 8'h5A);
        bus_addr = 0;

        // R2 enable bit
        wr(0, 8'h01); stat_peek(s); chk("R2 enable set", {7'b0, s[0]}, 8'h01);
        wr(0, 8'hFE); stat_peek(s); chk("R2 enable clear", {7'b0, s[0]}, 8'h00);

        // R3 load pulse
        wr(1, 8'hA5);
        stat_peek(s);
        chk("R3 txe low", {7'b0, s[1]}, 8'h00);
        chk("R3 ld_strobe", {7'b0, ld_strobe}, 8'h01);
        chk("R3 ld_data", ld_data, 8'hA5);
        tick();
        stat_peek(s);
        chk("R3 strobe one cycle", {7'b0, ld_strobe}, 8'h00);
        chk("R3 txe back", {7'b0, s[1]}, 8'h01);

        // R5/R4 shifter busy, pending waits, extra write ignored
        wr(1, 8'h3C);
        stat_peek(s);
        chk("R5 waits no strobe", {7'b0, ld_strobe}, 8'h00);
        chk("R5 txe low", {7'b0, s[1]}, 8'h00);
        wr(1, 8'h77);
        tick();
        chk("R4 still no strobe", {7'b0, ld_strobe}, 8'h00);
        shift_done = 1; #1;
        chk("R5 strobe with done", {7'b0, ld_strobe}, 8'h01);
        chk("R4 pending byte kept", ld_data, 8'h3C);
        tick(); idle();
        stat_peek(s);
        chk("R5 txe set", {7'b0, s[1]}, 8'h01);

        // R8 protected halt write
        dbg_halt = 1;
        wr(1, 8'h99);
        stat_peek(s);
        chk("R8 txe held", {7'b0, s[1]}, 8'h01);
        chk("R8 no strobe", {7'b0, ld_strobe}, 8'h00);
        shift_done = 1; tick(); idle();
        dbg_halt = 0; tick();
        chk("R8 nothing pending", {7'b0, ld_strobe}, 8'h00);

        // R10 enabled halt: receive clear and write act normally
        wr(0, 8'h01);
        dbg_halt = 1;
        rx_done = 1; rx_data = 8'hC3; tick(); idle();
        bus_rd = 1; bus_addr = 0; tick(); idle();
        bus_rd = 1; bus_addr = 1; tick(); idle();
        stat_peek(s);
        chk("R10 cleared in halt", {7'b0, s[2]}, 8'h00);
        wr(1, 8'h4E);
        chk("R10 write in halt loads", {7'b0, ld_strobe}, 8'h01);
        chk("R10 load data", ld_data, 8'h4E);
        dbg_halt = 0; tick();
        stat_peek(s);
        chk("R10 stays cleared", {7'b0, s[2]}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule